// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block tracks the position of one motor axis from a quadrature encoder. Two encoder phases, A and B, are brought into the system clock domain and decoded into up and down steps. The steps drive a 24-bit position counter. The phases can be read as a quadrature pair at single, double or quadruple resolution. They can also be read as separate up and down clocks, or as a clock plus a direction level. Besides the live counter, the block holds a preset value and an output latch that freezes a snapshot of the count. Software reads that snapshot while the axis keeps moving.

A host reaches the block through an 8-bit port with one select line. On the data side, writes fill the preset and reads return the output latch. Each access moves a shared byte pointer, least significant byte first. On the command side, the top two bits of a write pick one of four control registers, and reads return a status byte. A strobe pin, such as a periodic sample tick, copies the counter into the output latch without any host traffic.

Top module: `quad_pos_counter`

## Requirements
- R1: After reset the counter and the output latch are zero, the preset is all ones, the byte pointer is 0, counting from the encoder pins is disabled, the quadrature mode is off and the status byte reads 0x08.
- R2: A command write uses bits [7:6] to pick its target: 00 master control, 01 input control, 10 output control, 11 quadrature mode. A write to output control changes neither the counter nor the status. For quadrature mode, bits [1:0] select 00 off, 01 x1, 10 x2, 11 x4.
- R3: A data-port write stores the byte into the preset and a data-port read returns the output latch. Both address the byte at the pointer, with 0 as the least significant byte. Each data access advances the pointer 0, 1, 2 and back to 0.
- R4: Master control bit 5 (MRST) clears the input control and quadrature mode settings, the status flags and the pointer. It sets SIGN and loads the preset with all ones, and it leaves the counter untouched.
- R5: The other master control bits act as follows. Bit 4 clears CMP. Bit 3 copies the preset into the counter. Bit 2 zeroes the counter, clears CRY and BRW and sets SIGN. Bit 1 copies the counter into the output latch. Bit 0 resets the pointer. When one byte sets several bits, they take effect in the order reset, zero, preset-load, latch, then pointer and CMP clear.
- R6: Input control bit 3 enables counting from the encoder pins and bit 0 selects the non-quadrature mode. Bit 1 steps the counter up once and bit 2 steps it down once, whether or not counting is enabled. Setting both bits gives no step.
- R7: With quadrature mode off and bit 0 = 0, a rising A edge counts up and a rising B edge counts down. With bit 0 = 1, a rising A edge counts up when B is 0 and down when B is 1.
- R8: In quadrature mode the forward sequence of {A,B} is 00, 10, 11, 01, 00. x4 counts every single-phase transition, x2 counts only A transitions, and x1 counts only A transitions made while B is 0. A transition that changes both phases at once is ignored.
- R9: The status byte holds UP in bit 4, SIGN in bit 3, CMP in bit 2, CRY in bit 1 and BRW in bit 0. Counting up from all ones wraps to zero, toggles CRY and sets SIGN. Counting down from zero wraps to all ones, toggles BRW and clears SIGN. UP reflects the direction of the last step.
- R10: CMP toggles on every counter step whose result equals the preset.
- R11: A rising edge on the latch strobe pin, after synchronisation, copies the counter into the output latch in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe, one cycle per byte |
| bus_rd | input | 1 | Host read strobe, one cycle per byte |
| bus_cmd | input | 1 | 1 selects the command/status port, 0 the data port |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Host read byte: the latch byte at the pointer, or the status byte |
| enc_a | input | 1 | Encoder phase A (asynchronous) |
| enc_b | input | 1 | Encoder phase B (asynchronous) |
| enc_latch | input | 1 | Latch strobe pin (asynchronous) |

## Verification
The hardest states to reach from the ports are a transition that changes both phases at once, and the wrap at both ends of the 24-bit range. The wrap has to happen together with a preset match. The bench drives an illegal transition by switching A and B on the same clock. It reaches the wrap in a few cycles by loading an all-ones preset into the counter and using the single-step bits of input control to cross zero in both directions. It also walks one encoder trace through x4, x2, x1 and both non-quadrature modes, so that the mode selection depends on the phase history left behind by the previous mode.

// File: rtl/qpc_pkg.sv
`timescale 1ns/1ps
package qpc_pkg;
  typedef enum logic [1:0] {
    QM_OFF = 2'b00,
    QM_X1  = 2'b01,
    QM_X2  = 2'b10,
    QM_X4  = 2'b11
  } qmode_e;

  typedef enum logic [1:0] {
    SEL_MASTER = 2'b00,
    SEL_INPUT  = 2'b01,
    SEL_OUTPUT = 2'b10,
    SEL_QUAD   = 2'b11
  } csel_e;

  // master control byte, bit 5 down to bit 0
  typedef struct packed {
    logic mrst;
    logic rcmp;
    logic tpr;
    logic rcnt;
    logic tol;
    logic radr;
  } mcmd_t;

  // status byte, bit 4 down to bit 0
  typedef struct packed {
    logic up;
    logic sign;
    logic cmp;
    logic cry;
    logic brw;
  } stat_t;
endpackage

// File: rtl/qpc_sync.sv
`timescale 1ns/1ps
module qpc_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic [W-1:0] q_d
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [W-1:0]             dly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
      dly_q <= '0;
    end else begin
      stg_q[0] <= din;
      for (int i = 1; i < STAGES; i++) begin
        stg_q[i] <= stg_q[i-1];
      end
      dly_q <= stg_q[STAGES-1];
    end
  end

  assign q   = stg_q[STAGES-1];
  assign q_d = dly_q;
endmodule

// File: rtl/qpc_step.sv
`timescale 1ns/1ps
module qpc_step
  import qpc_pkg::*;
(
  input  qmode_e qmode,
  input  logic   mde,
  input  logic   ena,
  input  logic   a,
  input  logic   b,
  input  logic   a_d,
  input  logic   b_d,
  input  logic   sw_inc,
  input  logic   sw_dcr,
  output logic   step_up,
  output logic   step_dn
);
  logic a_chg, b_chg, single, q_dir_up;
  logic q_ev, enc_up, enc_dn;

  always_comb begin
    a_chg    = a ^ a_d;
    b_chg    = b ^ b_d;
    single   = a_chg ^ b_chg;
    q_dir_up = a ^ b_d;
    unique case (qmode)
      QM_X4:   q_ev = single;
      QM_X2:   q_ev = single & a_chg;
      QM_X1:   q_ev = single & a_chg & ~b_d;
      default: q_ev = 1'b0;
    endcase

    if (qmode != QM_OFF) begin
      enc_up = q_ev & q_dir_up;
      enc_dn = q_ev & ~q_dir_up;
    end else if (mde) begin
      enc_up = a & ~a_d & ~b;
      enc_dn = a & ~a_d & b;
    end else begin
      enc_up = a & ~a_d & ~(b & ~b_d);
      enc_dn = b & ~b_d & ~(a & ~a_d);
    end

    if (sw_inc | sw_dcr) begin
      step_up = sw_inc & ~sw_dcr;
      step_dn = sw_dcr & ~sw_inc;
    end else begin
      step_up = ena & enc_up;
      step_dn = ena & enc_dn;
    end
  end
endmodule

// File: rtl/qpc_core.sv
`timescale 1ns/1ps
module qpc_core
  import qpc_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int BYTE_W = 8,
  parameter int PTR_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_up,
  input  logic              step_dn,
  input  logic              mc_wr,
  input  mcmd_t             mc,
  input  logic              pr_wr,
  input  logic [PTR_W-1:0]  pr_sel,
  input  logic [BYTE_W-1:0] pr_data,
  input  logic              latch_ev,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  preset,
  output logic [CNT_W-1:0]  ol,
  output stat_t             status
);
  localparam int NB = CNT_W / BYTE_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_n, pr_q, pr_n, ol_q, ol_n;
  stat_t            st_q, st_n;
  logic             blk;

  always_comb begin
    pr_n  = pr_q;
    cnt_n = cnt_q;
    ol_n  = ol_q;
    st_n  = st_q;

    if (pr_wr) begin
      for (int i = 0; i < NB; i++) begin
        if (pr_sel == PTR_W'(i)) pr_n[i*BYTE_W +: BYTE_W] = pr_data;
      end
    end

    if (latch_ev) ol_n = cnt_q;

    if (mc_wr) begin
      if (mc.mrst) begin
        pr_n      = '1;
        st_n      = '0;
        st_n.sign = 1'b1;
      end
      if (mc.rcnt) begin
        cnt_n     = '0;
        st_n.cry  = 1'b0;
        st_n.brw  = 1'b0;
        st_n.sign = 1'b1;
      end
      if (mc.tpr)  cnt_n = pr_n;
      if (mc.tol)  ol_n  = cnt_n;
      if (mc.rcmp) st_n.cmp = 1'b0;
    end

    blk = mc_wr & (mc.rcnt | mc.tpr);
    if (!blk && (step_up ^ step_dn)) begin
      if (step_up) begin
        cnt_n   = cnt_q + ONE;
        st_n.up = 1'b1;
        if (&cnt_q) begin
          st_n.cry  = ~st_n.cry;
          st_n.sign = 1'b1;
        end
      end else begin
        cnt_n   = cnt_q - ONE;
        st_n.up = 1'b0;
        if (cnt_q == '0) begin
          st_n.brw  = ~st_n.brw;
          st_n.sign = 1'b0;
        end
      end
      if (cnt_n == pr_n) st_n.cmp = ~st_n.cmp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pr_q  <= '1;
      ol_q  <= '0;
      st_q  <= '{up: 1'b0, sign: 1'b1, cmp: 1'b0, cry: 1'b0, brw: 1'b0};
    end else begin
      cnt_q <= cnt_n;
      pr_q  <= pr_n;
      ol_q  <= ol_n;
      st_q  <= st_n;
    end
  end

  assign cnt    = cnt_q;
  assign preset = pr_q;
  assign ol     = ol_q;
  assign status = st_q;
endmodule

// File: rtl/quad_pos_counter.sv
`timescale 1ns/1ps
module quad_pos_counter
  import qpc_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_cmd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              enc_latch
);
  localparam int NB    = CNT_W / BYTE_W;
  localparam int PTR_W = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NB - 1);
  localparam int STAT_W = $bits(stat_t);

  // host decode
  csel_e      csel;
  logic       cmd_wr, mc_wr, ic_wr, qm_wr, data_acc, pr_wr;
  mcmd_t      mc;
  logic       sw_inc, sw_dcr, sw_step;

  // control state
  logic       mde_q, mde_n, ena_q, ena_n;
  qmode_e     qm_q, qm_n;
  logic [PTR_W-1:0] ptr_q, ptr_n;

  // synchronised pins
  logic [2:0] pin_s, pin_d;
  logic       a_s, b_s, a_d, b_d, latch_ev;
  logic       step_up, step_dn;

  logic [CNT_W-1:0] cnt, preset, ol;
  stat_t            status;
  logic [BYTE_W-1:0] ol_byte;

  always_comb begin
    csel     = csel_e'(bus_wdata[BYTE_W-1 -: 2]);
    cmd_wr   = bus_wr & bus_cmd;
    mc_wr    = cmd_wr & (csel == SEL_MASTER);
    ic_wr    = cmd_wr & (csel == SEL_INPUT);
    qm_wr    = cmd_wr & (csel == SEL_QUAD);
    mc       = mcmd_t'(bus_wdata[5:0]);
    sw_inc   = ic_wr & bus_wdata[1];
    sw_dcr   = ic_wr & bus_wdata[2];
    sw_step  = sw_inc | sw_dcr;
    data_acc = (bus_wr | bus_rd) & ~bus_cmd;
    pr_wr    = bus_wr & ~bus_cmd;
  end

  // control next state
  always_comb begin
    mde_n = mde_q;
    ena_n = ena_q;
    qm_n  = qm_q;
    ptr_n = ptr_q;
    if (ic_wr) begin
      mde_n = bus_wdata[0];
      ena_n = bus_wdata[3];
    end
    if (qm_wr) qm_n = qmode_e'(bus_wdata[1:0]);
    if (data_acc) ptr_n = (ptr_q == PTR_LAST) ? '0 : ptr_q + PTR_W'(1);
    if (mc_wr && (mc.mrst || mc.radr)) ptr_n = '0;
    if (mc_wr && mc.mrst) begin
      mde_n = 1'b0;
      ena_n = 1'b0;
      qm_n  = QM_OFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mde_q <= 1'b0;
      ena_q <= 1'b0;
      qm_q  <= QM_OFF;
      ptr_q <= '0;
    end else begin
      mde_q <= mde_n;
      ena_q <= ena_n;
      qm_q  <= qm_n;
      ptr_q <= ptr_n;
    end
  end

  qpc_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({enc_latch, enc_b, enc_a}),
    .q     (pin_s),
    .q_d   (pin_d)
  );

  assign a_s      = pin_s[0];
  assign b_s      = pin_s[1];
  assign a_d      = pin_d[0];
  assign b_d      = pin_d[1];
  assign latch_ev = pin_s[2] & ~pin_d[2];

  qpc_step i_step (
    .qmode   (qm_q),
    .mde     (mde_q),
    .ena     (ena_q),
    .a       (a_s),
    .b       (b_s),
    .a_d     (a_d),
    .b_d     (b_d),
    .sw_inc  (sw_inc),
    .sw_dcr  (sw_dcr),
    .step_up (step_up),
    .step_dn (step_dn)
  );

  qpc_core #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .PTR_W(PTR_W)) i_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_up  (step_up),
    .step_dn  (step_dn),
    .mc_wr    (mc_wr),
    .mc       (mc),
    .pr_wr    (pr_wr),
    .pr_sel   (ptr_q),
    .pr_data  (bus_wdata),
    .latch_ev (latch_ev),
    .cnt      (cnt),
    .preset   (preset),
    .ol       (ol),
    .status   (status)
  );

  always_comb begin
    ol_byte = '0;
    for (int i = 0; i < NB; i++) begin
      if (ptr_q == PTR_W'(i)) ol_byte = ol[i*BYTE_W +: BYTE_W];
    end
    bus_rdata = bus_cmd ? BYTE_W'({status}) : ol_byte;
  end

  logic unused_stat_w;
  assign unused_stat_w = (STAT_W == 0);
endmodule

// File: rtl/qpc_chk.sv
`timescale 1ns/1ps
module qpc_chk #(
  parameter int CNT_W = 24,
  parameter int PTR_W = 2,
  parameter int NB    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mc_wr,
  input logic [5:0]       mc,
  input logic             step_up,
  input logic             step_dn,
  input logic             sw_step,
  input logic             data_acc,
  input logic             latch_ev,
  input logic             a_s,
  input logic             b_s,
  input logic             a_d,
  input logic             b_d,
  input logic [PTR_W-1:0] ptr,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] preset,
  input logic [CNT_W-1:0] ol,
  input logic [4:0]       status
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NB - 1);

  // R4
  mrst_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_wr && mc[5]) |=> (preset == '1 && status[3] && status[2:0] == 3'b000));

  // R3
  ptr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !mc_wr) |=>
      (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + PTR_W'(1))));

  // R9
  count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !step_dn && !(mc_wr && (mc[3] || mc[2]))) |=>
      (cnt == $past(cnt) + CNT_W'(1) && status[4]));

  // R9
  carry_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !step_dn && !mc_wr && cnt == '1) |=>
      (cnt == '0 && status[3] && status[1] != $past(status[1])));

  // R8
  illegal_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_s != a_d) && (b_s != b_d) && !sw_step && !mc_wr) |=> $stable(cnt));

  // R11
  strobe_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_ev && !mc_wr) |=> (ol == $past(cnt)));
endmodule

bind quad_pos_counter qpc_chk #(.CNT_W(CNT_W), .PTR_W(PTR_W), .NB(NB)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mc_wr    (mc_wr),
  .mc       (bus_wdata[5:0]),
  .step_up  (step_up),
  .step_dn  (step_dn),
  .sw_step  (sw_step),
  .data_acc (data_acc),
  .latch_ev (latch_ev),
  .a_s      (a_s),
  .b_s      (b_s),
  .a_d      (a_d),
  .b_d      (b_d),
  .ptr      (ptr_q),
  .cnt      (cnt),
  .preset   (preset),
  .ol       (ol),
  .status   (status)
);

// File: tb/test_quad_pos_counter.sv
`timescale 1ns/1ps
module test_quad_pos_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_cmd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       enc_a = 1'b0, enc_b = 1'b0, enc_latch = 1'b0;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  quad_pos_counter i_quad_pos_counter (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_cmd(bus_cmd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .enc_a(enc_a), .enc_b(enc_b), .enc_latch(enc_latch)
  );

  typedef struct packed {
    logic [7:0]  cmd;   // 0 = none
    logic        a;
    logic        b;
    logic [23:0] exp;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{8'hC3, 1'b1, 1'b0, 24'd1}, '{8'h00, 1'b1, 1'b1, 24'd2},
    '{8'h00, 1'b0, 1'b1, 24'd3}, '{8'h00, 1'b0, 1'b0, 24'd4},
    '{8'h00, 1'b0, 1'b1, 24'd3}, '{8'h00, 1'b1, 1'b0, 24'd3},
    '{8'hC2, 1'b1, 1'b1, 24'd3}, '{8'h00, 1'b0, 1'b1, 24'd4},
    '{8'hC1, 1'b0, 1'b0, 24'd4}, '{8'h00, 1'b1, 1'b0, 24'd5},
    '{8'h00, 1'b0, 1'b0, 24'd4}, '{8'h00, 1'b0, 1'b1, 24'd4},
    '{8'h00, 1'b1, 1'b1, 24'd4}, '{8'hC0, 1'b0, 1'b0, 24'd4},
    '{8'h00, 1'b1, 1'b0, 24'd5}, '{8'h00, 1'b1, 1'b1, 24'd4},
    '{8'h49, 1'b0, 1'b0, 24'd4}, '{8'h00, 1'b1, 1'b0, 24'd5},
    '{8'h00, 1'b0, 1'b1, 24'd5}, '{8'h00, 1'b1, 1'b1, 24'd4}
  };

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%06h expected=%06h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic cmd, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_cmd = cmd; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_cmd = 1'b0;
  endtask

  task automatic rd(input logic cmd, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_cmd = cmd;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; bus_cmd = 1'b0;
  endtask

  task automatic rd_latch(output logic [23:0] v);
    logic [7:0] b0, b1, b2;
    rd(1'b0, b0); rd(1'b0, b1); rd(1'b0, b2);
    v = {b2, b1, b0};
  endtask

  task automatic rd_count(output logic [23:0] v);
    wr(1'b1, 8'h03);  // latch + pointer reset
    rd_latch(v);
  endtask

  task automatic rd_stat(output logic [7:0] s);
    rd(1'b1, s);
  endtask

  task automatic pins(input logic a, input logic b);
    @(negedge clk);
    enc_a = a; enc_b = b;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0]  s, b;
    logic [23:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd_stat(s);   check("R1 status", {16'h0, s}, 24'h000008);
    rd_latch(v);  check("R1 latch", v, 24'h000000);
    rd_count(v);  check("R1 counter", v, 24'h000000);
    wr(1'b1, 8'h0B); rd_latch(v);
    check("R1 preset ones", v, 24'hFFFFFF);

    // R3 preset bytes, LSB first, pointer wrap
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h12); wr(1'b0, 8'h34); wr(1'b0, 8'h56);
    wr(1'b1, 8'h0B);  // load, latch, pointer reset
    rd_latch(v);  check("R3 preset bytes", v, 24'h563412);
    rd(1'b0, b);  check("R3 pointer wrap", {16'h0, b}, 24'h000012);

    // R4 reset command, R9/R10 wrap and flags
    wr(1'b1, 8'h20);
    rd_stat(s);   check("R4 status after mrst", {16'h0, s}, 24'h000008);
    wr(1'b1, 8'h08);
    wr(1'b1, 8'h42);  // single step up
    rd_stat(s);   check("R9 carry wrap status", {16'h0, s}, 24'h00001A);
    rd_count(v);  check("R9 carry wrap count", v, 24'h000000);
    wr(1'b1, 8'h44);  // single step down
    rd_stat(s);   check("R10 borrow wrap with compare", {16'h0, s}, 24'h000007);
    rd_count(v);  check("R9 borrow wrap count", v, 24'hFFFFFF);
    wr(1'b1, 8'h10);
    rd_stat(s);   check("R5 compare clear", {16'h0, s}, 24'h000003);
    wr(1'b1, 8'h04);
    rd_stat(s);   check("R5 counter zero flags", {16'h0, s}, 24'h000008);

    // R2 output control has no effect
    wr(1'b1, 8'hBF);
    rd_stat(s);   check("R2 output ctrl status", {16'h0, s}, 24'h000008);
    rd_count(v);  check("R2 output ctrl count", v, 24'h000000);

    // R6 steps act while disabled; both bits give no step
    wr(1'b1, 8'h42); wr(1'b1, 8'h42); wr(1'b1, 8'h46);
    rd_stat(s);   check("R6 step status", {16'h0, s}, 24'h000018);
    rd_count(v);  check("R6 step count", v, 24'h000002);

    // R4 counter kept by reset command
    wr(1'b1, 8'h20);
    rd_count(v);  check("R4 counter kept", v, 24'h000002);

    // R5 ordering: zero then preset-load then latch
    wr(1'b1, 8'h0E);
    wr(1'b1, 8'h01);
    rd_latch(v);  check("R5 order", v, 24'hFFFFFF);

    // R11 latch strobe
    wr(1'b1, 8'h04);
    wr(1'b1, 8'h42);
    @(negedge clk); enc_latch = 1'b1;
    repeat (2) @(negedge clk); enc_latch = 1'b0;
    repeat (4) @(negedge clk);
    wr(1'b1, 8'h42);
    wr(1'b1, 8'h01);
    rd_latch(v);  check("R11 strobe snapshot", v, 24'h000001);
    rd_count(v);  check("R11 live count", v, 24'h000002);

    // R7/R8 encoder trace table
    wr(1'b1, 8'h48);
    wr(1'b1, 8'h04);
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].cmd != 8'h00) wr(1'b1, VECS[i].cmd);
      pins(VECS[i].a, VECS[i].b);
      rd_count(v);
      if (VECS[i].cmd == 8'h49 || i > 15 || (i >= 13 && i <= 15))
        check($sformatf("R7 vector %0d", i), v, VECS[i].exp);
      else
        check($sformatf("R8 vector %0d", i), v, VECS[i].exp);
    end

    // R4 reset command disables encoder counting
    wr(1'b1, 8'h20);
    pins(1'b0, 1'b1);
    pins(1'b1, 1'b1);
    rd_count(v);  check("R4 counting disabled", v, 24'h000004);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule